// File: doc/BRIEF.md
# Privilege-raising stack switch sequencer

This block carries out the stack change that accompanies a far call made through a gate into a non-conforming code segment of higher privilege. When it is started, it takes the target privilege level, the layout and limit of the current task-state segment, the width of the gate and its parameter count, and the caller's stack and code pointers. It then works out where the inner-ring stack pointer and selector sit in the task-state segment and checks that location against the segment's limit. It fetches both values over a read port and validates the new stack segment. It checks that the new stack has room for everything it will hold. Only then does it write the caller's linkage and parameters onto the new stack through a push port.

The surrounding control logic looks up the stack segment's descriptor attributes from the selector the block reads and holds them on the inputs. The caller's parameters are fetched one at a time through a second read port, addressed in the caller's stack. The block finishes in one of two ways. It may pulse a completion strobe together with the committed stack selector, stack pointer, code selector and privilege level. Or it may pulse a fault strobe with a fault class and an error code, in which case no push has been issued and no committed output has changed.

Top module: `stk_swap_seq`

## Requirements
- R1: After reset, `done`, `fault_vld`, `push_vld`, `tss_rd_req` and `prm_rd_req` are low, and `new_ss`, `new_esp`, `new_cs` and `new_cpl` are zero.
- R2: The stack slot in the task-state segment depends on its layout. For a 32-bit layout, a 4-byte read (`tss_rd_wide`=1) at offset 8*DPL+4 is followed by a 2-byte read at 8*DPL+8. For a 16-bit layout, a 2-byte read at 4*DPL+2 is followed by a 2-byte read at 4*DPL+4. Only the low 16 bits of a 2-byte read are used.
- R3: A limit fault (class TS, `fault_kind`=1) is raised if the slot offset plus 7 (32-bit layout) or plus 4 (16-bit layout) exceeds `tss_limit`. Its code is `cur_tss_sel` with bits 1:0 cleared. Equality passes. On a limit fault no read of the task-state segment is issued.
- R4: A new stack selector whose bits 15:2 are all zero raises class TS with code 0.
- R5: Class TS with code = stack selector with bits 1:0 cleared is raised in three cases: the selector's bits 1:0 differ from the target DPL, `ss_dpl` differs from the target DPL, or `ss_wdata` is low. This check takes priority over R6 and R7.
- R6: A stack segment with `ss_present` low raises class SS (`fault_kind`=2), with code = stack selector with bits 1:0 cleared.
- R7: The required space is W*N + 4*W bytes, where W is 4 for a 32-bit gate and 2 for a 16-bit gate. If the new stack pointer is below this figure, class SS is raised with the stack selector code. A pointer equal to the figure passes.
- R8: Only bits 4:0 of `param_cnt` are used as the parameter count N.
- R9: Pushes are W bytes wide (`push_wide`=1 for a 32-bit gate), at descending addresses starting at new pointer minus W. The order is: old SS, old ESP, the N parameters, old CS, old EIP. For a 16-bit gate, each value is truncated to its low 16 bits.
- R10: Parameter j (j = N-1 down to 0) is read from `old_esp` + j*W, so the highest address is read first. The pushed value is the returned word.
- R11: On completion, `done` pulses for one cycle. At that point `new_ss` is the selector read, `new_esp` is the new pointer minus the required space, `new_cpl` is the target DPL, and `new_cs` is `gate_cs_sel` with bits 1:0 replaced by the target DPL.
- R12: A fault pulses `fault_vld` for one cycle. It issues no push and leaves `new_ss`, `new_esp`, `new_cs` and `new_cpl` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a switch (ignored while busy) |
| tgt_dpl | input | 2 | Privilege level of the target code segment |
| tss_is32 | input | 1 | Task-state segment uses the 32-bit layout |
| tss_limit | input | 32 | Limit of the task-state segment |
| cur_tss_sel | input | 16 | Selector of the current task-state segment |
| gate_is32 | input | 1 | Gate is 32-bit |
| gate_cs_sel | input | 16 | Code selector taken from the gate |
| param_cnt | input | 8 | Parameter count field of the gate |
| old_ss | input | 16 | Caller stack selector |
| old_esp | input | 32 | Caller stack pointer |
| old_cs | input | 16 | Caller code selector |
| old_eip | input | 32 | Caller return offset |
| ss_dpl | input | 2 | Descriptor privilege of the new stack segment |
| ss_present | input | 1 | New stack segment is present |
| ss_wdata | input | 1 | New stack segment is a writable data segment |
| tss_rd_req | output | 1 | Task-state segment read request |
| tss_rd_addr | output | 32 | Byte offset of the read |
| tss_rd_wide | output | 1 | 4-byte read when high, 2-byte when low |
| tss_rd_valid | input | 1 | Read data valid |
| tss_rd_data | input | 32 | Read data |
| prm_rd_req | output | 1 | Caller-stack parameter read request |
| prm_rd_addr | output | 32 | Offset in the caller stack |
| prm_rd_wide | output | 1 | 4-byte read when high |
| prm_rd_valid | input | 1 | Parameter data valid |
| prm_rd_data | input | 32 | Parameter data |
| push_vld | output | 1 | Push write strobe |
| push_addr | output | 32 | Offset in the new stack |
| push_wide | output | 1 | 4-byte push when high |
| push_data | output | 32 | Value pushed |
| done | output | 1 | Completion pulse |
| fault_vld | output | 1 | Fault pulse |
| fault_kind | output | 2 | 1 = TS class, 2 = SS class |
| fault_code | output | 16 | Fault error code |
| new_ss | output | 16 | Committed stack selector |
| new_esp | output | 32 | Committed stack pointer |
| new_cs | output | 16 | Committed code selector |
| new_cpl | output | 2 | Committed privilege level |

## Verification
The bench goes after the limit comparison at exact equality and one byte past it, for both layouts. A design that used greater-or-equal would fault on a legal slot, and one with the wrong addend would read past the limit. It also runs the space test at an exact fit and one byte short, where an off-by-one either lets a push wrap below zero or refuses a call that fits. A parameter count of 33 catches a missing 5-bit mask, which would copy 33 words instead of 1. Every parameter push is matched against a value that encodes its source address, so copying in the wrong order or with the wrong stride shows up as a mismatch on a specific slot. Each fault case also checks that nothing was pushed and that the committed outputs held their values, since a design that commits early would corrupt them.

// File: rtl/stk_swap_pkg.sv
// Shared types of the stack switch sequencer.
package stk_swap_pkg;

    // Fault class reported with fault_vld.
    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_TS   = 2'd1,
        FLT_SS   = 2'd2
    } flt_kind_e;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LIMIT,
        ST_READ_TSS,
        ST_CHECK,
        ST_PUSH,
        ST_COPY,
        ST_DONE,
        ST_FAULT
    } seq_state_e;

    // Fault verdict: class and error code.
    typedef struct packed {
        flt_kind_e   kind;
        logic [15:0] code;
    } flt_t;

endpackage

// File: rtl/stk_swap_tss_map.sv
// Maps a target privilege level to the byte offsets of the inner stack
// pointer and selector in the task-state segment and flags a slot that
// runs past the segment limit. Assumes DPL fits 2 bits; purely combinational.
module stk_swap_tss_map #(
    parameter int ADDR_W = 32
) (
    input  logic [1:0]        dpl,
    input  logic              tss_is32,
    input  logic [ADDR_W-1:0] tss_limit,
    output logic [ADDR_W-1:0] sp_off,
    output logic [ADDR_W-1:0] ss_off,
    output logic              limit_bad
);
    localparam int EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] last_byte;

    // Offset selection and inclusive-limit comparison.
    always_comb begin
        if (tss_is32) begin
            sp_off    = ADDR_W'({dpl, 3'b000}) + ADDR_W'(4);
            ss_off    = sp_off + ADDR_W'(4);
            last_byte = {1'b0, sp_off} + EXT_W'(7);
        end else begin
            sp_off    = ADDR_W'({dpl, 2'b00}) + ADDR_W'(2);
            ss_off    = sp_off + ADDR_W'(2);
            last_byte = {1'b0, sp_off} + EXT_W'(4);
        end
        limit_bad = last_byte > {1'b0, tss_limit};
    end
endmodule

// File: rtl/stk_swap_ss_check.sv
// Validates the new stack segment and its free space, in a fixed priority:
// null selector, privilege/type mismatch, not present, too little space.
// Assumes the descriptor attributes belong to the selector given.
module stk_swap_ss_check
    import stk_swap_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SEL_W  = 16,
    parameter int PCNT_W = 5
) (
    input  logic [SEL_W-1:0]  ss_sel,
    input  logic [1:0]        ss_dpl,
    input  logic              ss_present,
    input  logic              ss_wdata,
    input  logic [1:0]        code_dpl,
    input  logic [ADDR_W-1:0] avail,
    input  logic [PCNT_W-1:0] pcnt,
    input  logic              gate_is32,
    output logic [ADDR_W-1:0] need,
    output flt_t              verdict
);
    localparam logic [SEL_W-1:0] RPL_MASK = SEL_W'(3);

    logic [SEL_W-1:0] sel_code;

    // Bytes needed on the new stack: parameters plus four linkage items.
    always_comb begin
        if (gate_is32)
            need = (ADDR_W'(pcnt) << 2) + ADDR_W'(16);
        else
            need = (ADDR_W'(pcnt) << 1) + ADDR_W'(8);
    end

    assign sel_code = ss_sel & ~RPL_MASK;

    // Prioritised verdict.
    always_comb begin
        verdict.kind = FLT_NONE;
        verdict.code = '0;
        if (sel_code == '0) begin
            verdict.kind = FLT_TS;
        end else if ((ss_sel[1:0] != code_dpl) || (ss_dpl != code_dpl) || !ss_wdata) begin
            verdict.kind = FLT_TS;
            verdict.code = 16'(sel_code);
        end else if (!ss_present || (avail < need)) begin
            verdict.kind = FLT_SS;
            verdict.code = 16'(sel_code);
        end
    end
endmodule

// File: rtl/stk_swap_push_mux.sv
// Picks the value for the current push slot (linkage item or copied
// parameter) and narrows it to 16 bits for a 16-bit gate.
module stk_swap_push_mux #(
    parameter int ADDR_W = 32,
    parameter int SEL_W  = 16
) (
    input  logic [1:0]        slot,
    input  logic              from_prm,
    input  logic              gate_is32,
    input  logic [SEL_W-1:0]  old_ss,
    input  logic [ADDR_W-1:0] old_esp,
    input  logic [SEL_W-1:0]  old_cs,
    input  logic [ADDR_W-1:0] old_eip,
    input  logic [ADDR_W-1:0] prm_data,
    output logic [ADDR_W-1:0] data
);
    localparam int HALF_W = ADDR_W / 2;

    logic [ADDR_W-1:0] raw;

    // Slot 0/1/2/3 = old SS, old ESP, old CS, old EIP; parameters override.
    always_comb begin
        unique case (slot)
            2'd0:    raw = ADDR_W'(old_ss);
            2'd1:    raw = old_esp;
            2'd2:    raw = ADDR_W'(old_cs);
            default: raw = old_eip;
        endcase
        if (from_prm)
            raw = prm_data;
        data = gate_is32 ? raw : {{(ADDR_W-HALF_W){1'b0}}, raw[HALF_W-1:0]};
    end
endmodule

// File: rtl/stk_swap_seq.sv
// Stack switch sequencer for a privilege-raising gate call. Reads the inner
// stack slot from the task-state segment, validates it, then pushes the
// caller's linkage and parameters. Committed outputs change only on success.
// Assumes the ss_* attribute inputs stay valid from the stack read until the
// check step, and that the read ports answer with valid held per request.
module stk_swap_seq
    import stk_swap_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SEL_W     = 16,
    parameter int PCNT_IN_W = 8,
    parameter int PCNT_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        tgt_dpl,
    input  logic              tss_is32,
    input  logic [ADDR_W-1:0] tss_limit,
    input  logic [SEL_W-1:0]  cur_tss_sel,
    input  logic              gate_is32,
    input  logic [SEL_W-1:0]  gate_cs_sel,
    input  logic [PCNT_IN_W-1:0] param_cnt,
    input  logic [SEL_W-1:0]  old_ss,
    input  logic [ADDR_W-1:0] old_esp,
    input  logic [SEL_W-1:0]  old_cs,
    input  logic [ADDR_W-1:0] old_eip,
    input  logic [1:0]        ss_dpl,
    input  logic              ss_present,
    input  logic              ss_wdata,
    output logic              tss_rd_req,
    output logic [ADDR_W-1:0] tss_rd_addr,
    output logic              tss_rd_wide,
    input  logic              tss_rd_valid,
    input  logic [ADDR_W-1:0] tss_rd_data,
    output logic              prm_rd_req,
    output logic [ADDR_W-1:0] prm_rd_addr,
    output logic              prm_rd_wide,
    input  logic              prm_rd_valid,
    input  logic [ADDR_W-1:0] prm_rd_data,
    output logic              push_vld,
    output logic [ADDR_W-1:0] push_addr,
    output logic              push_wide,
    output logic [ADDR_W-1:0] push_data,
    output logic              done,
    output logic              fault_vld,
    output logic [1:0]        fault_kind,
    output logic [SEL_W-1:0]  fault_code,
    output logic [SEL_W-1:0]  new_ss,
    output logic [ADDR_W-1:0] new_esp,
    output logic [SEL_W-1:0]  new_cs,
    output logic [1:0]        new_cpl
);
    localparam int HALF_W = ADDR_W / 2;
    localparam logic [SEL_W-1:0] RPL_MASK = SEL_W'(3);

    seq_state_e        st_q;
    logic [1:0]        dpl_q;
    logic              tss32_q, gate32_q;
    logic [ADDR_W-1:0] limit_q;
    logic [SEL_W-1:0]  tss_sel_q, gcs_q;
    logic [PCNT_W-1:0] pcnt_q, prm_q;
    logic [SEL_W-1:0]  oss_q, ocs_q;
    logic [ADDR_W-1:0] oesp_q, oeip_q;
    logic [ADDR_W-1:0] esp_tss_q, sp_q;
    logic [SEL_W-1:0]  ss_tss_q;
    logic              rd_step_q;
    logic [1:0]        slot_q;
    flt_kind_e         flt_kind_q;
    logic [SEL_W-1:0]  flt_code_q;
    logic [SEL_W-1:0]  new_ss_q, new_cs_q;
    logic [ADDR_W-1:0] new_esp_q;
    logic [1:0]        new_cpl_q;

    logic [ADDR_W-1:0] sp_off, ss_off, need, wstep, next_sp;
    logic              limit_bad;
    flt_t              verdict;

    stk_swap_tss_map #(.ADDR_W(ADDR_W)) u_map (
        .dpl       (dpl_q),
        .tss_is32  (tss32_q),
        .tss_limit (limit_q),
        .sp_off    (sp_off),
        .ss_off    (ss_off),
        .limit_bad (limit_bad)
    );

    stk_swap_ss_check #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .PCNT_W(PCNT_W)) u_chk (
        .ss_sel     (ss_tss_q),
        .ss_dpl     (ss_dpl),
        .ss_present (ss_present),
        .ss_wdata   (ss_wdata),
        .code_dpl   (dpl_q),
        .avail      (esp_tss_q),
        .pcnt       (pcnt_q),
        .gate_is32  (gate32_q),
        .need       (need),
        .verdict    (verdict)
    );

    stk_swap_push_mux #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_mux (
        .slot      (slot_q),
        .from_prm  (st_q == ST_COPY),
        .gate_is32 (gate32_q),
        .old_ss    (oss_q),
        .old_esp   (oesp_q),
        .old_cs    (ocs_q),
        .old_eip   (oeip_q),
        .prm_data  (prm_rd_data),
        .data      (push_data)
    );

    // Push stride and the pointer after the current push.
    assign wstep   = gate32_q ? ADDR_W'(4) : ADDR_W'(2);
    assign next_sp = sp_q - wstep;

    // Read ports, push port and status drive.
    always_comb begin
        tss_rd_req  = (st_q == ST_READ_TSS);
        tss_rd_addr = rd_step_q ? ss_off : sp_off;
        tss_rd_wide = tss32_q && !rd_step_q;
        prm_rd_req  = (st_q == ST_COPY);
        prm_rd_addr = oesp_q + (ADDR_W'(prm_q) << (gate32_q ? 2 : 1));
        prm_rd_wide = gate32_q;
        push_vld    = (st_q == ST_PUSH) || ((st_q == ST_COPY) && prm_rd_valid);
        push_addr   = next_sp;
        push_wide   = gate32_q;
        done        = (st_q == ST_DONE);
        fault_vld   = (st_q == ST_FAULT);
        fault_kind  = flt_kind_q;
        fault_code  = flt_code_q;
        new_ss      = new_ss_q;
        new_esp     = new_esp_q;
        new_cs      = new_cs_q;
        new_cpl     = new_cpl_q;
    end

    // Sequencer: latch, limit test, slot reads, checks, pushes, commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            dpl_q      <= '0;
            tss32_q    <= 1'b0;
            gate32_q   <= 1'b0;
            limit_q    <= '0;
            tss_sel_q  <= '0;
            gcs_q      <= '0;
            pcnt_q     <= '0;
            prm_q      <= '0;
            oss_q      <= '0;
            ocs_q      <= '0;
            oesp_q     <= '0;
            oeip_q     <= '0;
            esp_tss_q  <= '0;
            ss_tss_q   <= '0;
            sp_q       <= '0;
            rd_step_q  <= 1'b0;
            slot_q     <= '0;
            flt_kind_q <= FLT_NONE;
            flt_code_q <= '0;
            new_ss_q   <= '0;
            new_cs_q   <= '0;
            new_esp_q  <= '0;
            new_cpl_q  <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        dpl_q      <= tgt_dpl;
                        tss32_q    <= tss_is32;
                        gate32_q   <= gate_is32;
                        limit_q    <= tss_limit;
                        tss_sel_q  <= cur_tss_sel;
                        gcs_q      <= gate_cs_sel;
                        pcnt_q     <= PCNT_W'(param_cnt);
                        oss_q      <= old_ss;
                        ocs_q      <= old_cs;
                        oesp_q     <= old_esp;
                        oeip_q     <= old_eip;
                        flt_kind_q <= FLT_NONE;
                        flt_code_q <= '0;
                        st_q       <= ST_LIMIT;
                    end
                end
                ST_LIMIT: begin
                    if (limit_bad) begin
                        flt_kind_q <= FLT_TS;
                        flt_code_q <= tss_sel_q & ~RPL_MASK;
                        st_q       <= ST_FAULT;
                    end else begin
                        rd_step_q  <= 1'b0;
                        st_q       <= ST_READ_TSS;
                    end
                end
                ST_READ_TSS: begin
                    if (tss_rd_valid) begin
                        if (!rd_step_q) begin
                            esp_tss_q <= tss32_q ? tss_rd_data
                                                 : {{(ADDR_W-HALF_W){1'b0}}, tss_rd_data[HALF_W-1:0]};
                            rd_step_q <= 1'b1;
                        end else begin
                            ss_tss_q  <= tss_rd_data[SEL_W-1:0];
                            st_q      <= ST_CHECK;
                        end
                    end
                end
                ST_CHECK: begin
                    if (verdict.kind != FLT_NONE) begin
                        flt_kind_q <= verdict.kind;
                        flt_code_q <= SEL_W'(verdict.code);
                        st_q       <= ST_FAULT;
                    end else begin
                        sp_q   <= esp_tss_q;
                        slot_q <= 2'd0;
                        st_q   <= ST_PUSH;
                    end
                end
                ST_PUSH: begin
                    sp_q <= next_sp;
                    if (slot_q == 2'd1) begin
                        slot_q <= 2'd2;
                        if (pcnt_q != '0) begin
                            prm_q <= pcnt_q - PCNT_W'(1);
                            st_q  <= ST_COPY;
                        end
                    end else if (slot_q == 2'd3) begin
                        new_esp_q <= next_sp;
                        new_ss_q  <= ss_tss_q;
                        new_cpl_q <= dpl_q;
                        new_cs_q  <= (gcs_q & ~RPL_MASK) | SEL_W'(dpl_q);
                        st_q      <= ST_DONE;
                    end else begin
                        slot_q <= slot_q + 2'd1;
                    end
                end
                ST_COPY: begin
                    if (prm_rd_valid) begin
                        sp_q <= next_sp;
                        if (prm_q == '0)
                            st_q <= ST_PUSH;
                        else
                            prm_q <= prm_q - PCNT_W'(1);
                    end
                end
                ST_DONE:  st_q <= ST_IDLE;
                ST_FAULT: st_q <= ST_IDLE;
                default:  st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/stk_swap_seq_chk.sv
// Port-level protocol checker for the stack switch sequencer, bound below.
module stk_swap_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int SEL_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_vld,
    input logic [ADDR_W-1:0] push_addr,
    input logic              push_wide,
    input logic              done,
    input logic              fault_vld,
    input logic [1:0]        fault_kind,
    input logic [SEL_W-1:0]  new_ss,
    input logic [ADDR_W-1:0] new_esp
);
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_vld |=> !fault_vld);

    // R12
    commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(new_esp) && $stable(new_ss)));

    // R9
    push_descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_vld && $past(push_vld)) |->
            (push_addr == $past(push_addr) - (push_wide ? ADDR_W'(4) : ADDR_W'(2))));

    // R3
    fault_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_vld |-> (fault_kind == 2'd1 || fault_kind == 2'd2));

    // R12
    no_push_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault_vld) |-> !push_vld);
endmodule

bind stk_swap_seq stk_swap_seq_chk #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_vld   (push_vld),
    .push_addr  (push_addr),
    .push_wide  (push_wide),
    .done       (done),
    .fault_vld  (fault_vld),
    .fault_kind (fault_kind),
    .new_ss     (new_ss),
    .new_esp    (new_esp)
);

// File: tb/stk_swap_seq_tb_top.sv
`timescale 1ns/1ps
// Sweep bench for the stack switch sequencer: models both read ports,
// logs pushes, and compares against values computed from the requirements.
module stk_swap_seq_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        start = 1'b0;
    logic [1:0]  tgt_dpl = '0;
    logic        tss_is32 = 1'b0, gate_is32 = 1'b0;
    logic [31:0] tss_limit = '0;
    logic [15:0] cur_tss_sel = '0, gate_cs_sel = '0;
    logic [7:0]  param_cnt = '0;
    logic [15:0] old_ss = '0, old_cs = '0;
    logic [31:0] old_esp = '0, old_eip = '0;
    logic [1:0]  ss_dpl = '0;
    logic        ss_present = 1'b0, ss_wdata = 1'b0;
    logic        tss_rd_req, tss_rd_wide, prm_rd_req, prm_rd_wide;
    logic [31:0] tss_rd_addr, prm_rd_addr;
    logic        tss_rd_valid = 1'b0, prm_rd_valid = 1'b0;
    logic [31:0] tss_rd_data = '0, prm_rd_data = '0;
    logic        push_vld, push_wide, done, fault_vld;
    logic [31:0] push_addr, push_data, new_esp;
    logic [1:0]  fault_kind, new_cpl;
    logic [15:0] fault_code, new_ss, new_cs;

    stk_swap_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .tgt_dpl(tgt_dpl),
        .tss_is32(tss_is32), .tss_limit(tss_limit), .cur_tss_sel(cur_tss_sel),
        .gate_is32(gate_is32), .gate_cs_sel(gate_cs_sel), .param_cnt(param_cnt),
        .old_ss(old_ss), .old_esp(old_esp), .old_cs(old_cs), .old_eip(old_eip),
        .ss_dpl(ss_dpl), .ss_present(ss_present), .ss_wdata(ss_wdata),
        .tss_rd_req(tss_rd_req), .tss_rd_addr(tss_rd_addr), .tss_rd_wide(tss_rd_wide),
        .tss_rd_valid(tss_rd_valid), .tss_rd_data(tss_rd_data),
        .prm_rd_req(prm_rd_req), .prm_rd_addr(prm_rd_addr), .prm_rd_wide(prm_rd_wide),
        .prm_rd_valid(prm_rd_valid), .prm_rd_data(prm_rd_data),
        .push_vld(push_vld), .push_addr(push_addr), .push_wide(push_wide),
        .push_data(push_data), .done(done), .fault_vld(fault_vld),
        .fault_kind(fault_kind), .fault_code(fault_code), .new_ss(new_ss),
        .new_esp(new_esp), .new_cs(new_cs), .new_cpl(new_cpl)
    );

    // Bench-side copy of the task-state segment contents.
    logic [31:0] c_esp = '0;
    logic [15:0] c_ss_sel = '0;

    int n_tests = 0, n_fail = 0;
    int lg_n = 0, rd_cnt = 0, wide_err = 0;
    logic [31:0] lg_addr [0:63];
    logic [31:0] lg_data [0:63];
    logic        lg_wide [0:63];
    bit saw_done, saw_fault;
    logic [1:0]  got_kind;
    logic [15:0] got_code;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Read-port models: answer every request cycle with data for its address.
    initial begin
        forever begin
            @(negedge clk);
            begin
                logic [31:0] spo;
                spo = tss_is32 ? (32'(tgt_dpl) * 8 + 4) : (32'(tgt_dpl) * 4 + 2);
                tss_rd_valid = tss_rd_req;
                if (tss_rd_req) begin
                    rd_cnt++;
                    if (tss_rd_addr == spo) begin
                        if (tss_rd_wide != tss_is32) wide_err++;
                        tss_rd_data = tss_is32 ? c_esp : {16'hEEEE, c_esp[15:0]};
                    end else if (tss_rd_addr == spo + (tss_is32 ? 32'd4 : 32'd2)) begin
                        if (tss_rd_wide) wide_err++;
                        tss_rd_data = {16'hEEEE, c_ss_sel};
                    end else begin
                        tss_rd_data = 32'hBAD0BAD0;
                    end
                end
                prm_rd_valid = prm_rd_req;
                if (prm_rd_req) begin
                    if (prm_rd_wide != gate_is32) wide_err++;
                    prm_rd_data = 32'hC000_0000 | prm_rd_addr;
                end
            end
        end
    end

    // Push logger, sampled mid low phase.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (push_vld && lg_n < 64) begin
                lg_addr[lg_n] = push_addr;
                lg_data[lg_n] = push_data;
                lg_wide[lg_n] = push_wide;
                lg_n++;
            end
        end
    end

    task automatic set_good(input int d, input bit t32, input bit g32, input int pc);
        tgt_dpl     = 2'(d);
        tss_is32    = t32;
        gate_is32   = g32;
        param_cnt   = 8'(pc);
        tss_limit   = 32'h67;
        cur_tss_sel = 16'h002B;
        gate_cs_sel = 16'h003B;
        old_ss      = 16'h0123;
        old_esp     = 32'h0002_0F00;
        old_cs      = 16'h001B;
        old_eip     = 32'h1234_5678;
        c_esp       = t32 ? (32'h0004_0000 + 32'(d) * 256) : (32'h0000_9000 + 32'(d) * 256);
        c_ss_sel    = 16'h0050 + 16'(d) * 8 + 16'(d);
        ss_dpl      = 2'(d);
        ss_present  = 1'b1;
        ss_wdata    = 1'b1;
    endtask

    task automatic fire();
        lg_n = 0; rd_cnt = 0; wide_err = 0;
        saw_done = 0; saw_fault = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 3000 && !saw_done && !saw_fault; i++) begin
            @(negedge clk); #2;
            if (done) saw_done = 1;
            if (fault_vld) begin
                saw_fault = 1; got_kind = fault_kind; got_code = fault_code;
            end
        end
    endtask

    function automatic logic [31:0] nar(input logic [31:0] v);
        return gate_is32 ? v : {16'h0, v[15:0]};
    endfunction

    task automatic check_ok(input string tag);
        int n, w, bad;
        logic [31:0] esp0, need, ea, ed;
        n    = int'(param_cnt & 8'h1F);
        w    = gate_is32 ? 4 : 2;
        need = 32'(n * w + 4 * w);
        esp0 = tss_is32 ? c_esp : {16'h0, c_esp[15:0]};
        chk(saw_done && !saw_fault, "R11", {tag, " completion"}, 32'(saw_done), 1);
        chk(wide_err == 0 && rd_cnt == 2, "R2", {tag, " slot reads"}, 32'(rd_cnt), 2);
        chk(lg_n == n + 4, "R8", {tag, " push count"}, 32'(lg_n), 32'(n + 4));
        bad = -1;
        for (int k = 0; k < n + 4 && k < lg_n; k++) begin
            ea = esp0 - 32'((k + 1) * w);
            if (k == 0) ed = nar({16'h0, old_ss});
            else if (k == 1) ed = nar(old_esp);
            else if (k == n + 2) ed = nar({16'h0, old_cs});
            else if (k == n + 3) ed = nar(old_eip);
            else ed = nar(32'hC000_0000 | (old_esp + 32'((n - 1 - (k - 2)) * w)));
            if (bad < 0 && (lg_addr[k] != ea || lg_data[k] != ed || lg_wide[k] != gate_is32)) begin
                bad = k;
                chk(0, "R9 R10", $sformatf("%s push %0d data", tag, k), lg_data[k], ed);
            end
        end
        if (bad < 0) chk(1, "R9 R10", tag, 0, 0);
        chk(new_esp == esp0 - need, "R11", {tag, " new_esp"}, new_esp, esp0 - need);
        chk(new_ss == c_ss_sel && new_cpl == tgt_dpl &&
            new_cs == ((gate_cs_sel & 16'hFFFC) | 16'(tgt_dpl)),
            "R11", {tag, " new_ss/cs/cpl"}, {new_ss, new_cs}, {c_ss_sel, (gate_cs_sel & 16'hFFFC) | 16'(tgt_dpl)});
    endtask

    task automatic check_fault(input string req, input logic [1:0] k, input logic [15:0] c,
                               input bit no_reads);
        logic [31:0] pe, ps;
        pe = new_esp; ps = {new_ss, new_cs};
        fire();
        chk(saw_fault && got_kind == k && got_code == c, req, "fault kind/code",
            {14'h0, got_kind, got_code}, {14'h0, k, c});
        chk(lg_n == 0 && new_esp == pe && {new_ss, new_cs} == ps, "R12",
            {req, " no push, outputs held"}, 32'(lg_n), 0);
        if (no_reads) chk(rd_cnt == 0, "R3", "no slot read on limit fault", 32'(rd_cnt), 0);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int pcs [4];
        pcs = '{0, 2, 5, 33};
        repeat (3) @(negedge clk);
        #2;
        chk(!done && !fault_vld && !push_vld && !tss_rd_req && !prm_rd_req, "R1",
            "strobes in reset", {27'h0, done, fault_vld, push_vld, tss_rd_req, prm_rd_req}, 0);
        chk(new_esp == 0 && new_ss == 0 && new_cs == 0 && new_cpl == 0, "R1",
            "committed outputs in reset", new_esp, 0);
        @(negedge clk); rst_n = 1'b1;

        // Main sweep: privilege x layout x gate width x count (R2 R8 R9 R10 R11).
        for (int d = 0; d < 3; d++)
            for (int t = 0; t < 2; t++)
                for (int g = 0; g < 2; g++)
                    for (int p = 0; p < 4; p++) begin
                        set_good(d, t[0], g[0], pcs[p]);
                        fire();
                        check_ok($sformatf("R2 sweep d%0d t%0d g%0d n%0d", d, t, g, pcs[p]));
                    end

        // R3 limit boundaries, 32-bit layout: slot 12, last byte 19.
        set_good(1, 1'b1, 1'b1, 2); tss_limit = 32'd19; fire(); check_ok("R3 limit equal 32");
        set_good(1, 1'b1, 1'b1, 2); tss_limit = 32'd18; check_fault("R3", 2'd1, 16'h0028, 1);
        // 16-bit layout: slot 6, bound 10.
        set_good(1, 1'b0, 1'b0, 2); tss_limit = 32'd10; fire(); check_ok("R3 limit equal 16");
        set_good(1, 1'b0, 1'b0, 2); tss_limit = 32'd9; check_fault("R3", 2'd1, 16'h0028, 1);

        // R4 null selector (RPL matches so only the null rule applies).
        set_good(1, 1'b1, 1'b1, 2); c_ss_sel = 16'h0001; check_fault("R4", 2'd1, 16'h0000, 0);
        // R5 RPL, DPL, type mismatches.
        set_good(1, 1'b1, 1'b1, 2); c_ss_sel = 16'h005A; check_fault("R5", 2'd1, 16'h0058, 0);
        set_good(1, 1'b1, 1'b1, 2); ss_dpl = 2'd2; check_fault("R5", 2'd1, 16'h0058, 0);
        set_good(1, 1'b1, 1'b1, 2); ss_wdata = 1'b0; check_fault("R5", 2'd1, 16'h0058, 0);
        // R5 has priority over R6.
        set_good(1, 1'b1, 1'b1, 2); ss_wdata = 1'b0; ss_present = 1'b0;
        check_fault("R5", 2'd1, 16'h0058, 0);
        // R6 not present.
        set_good(1, 1'b1, 1'b1, 2); ss_present = 1'b0; check_fault("R6", 2'd2, 16'h0058, 0);
        // R7 space: 32-bit gate, 2 params -> 24 bytes.
        set_good(1, 1'b1, 1'b1, 2); c_esp = 32'd24; fire(); check_ok("R7 exact fit 32");
        set_good(1, 1'b1, 1'b1, 2); c_esp = 32'd23; check_fault("R7", 2'd2, 16'h0058, 0);
        // R7 space: 16-bit gate, 2 params -> 12 bytes.
        set_good(1, 1'b1, 1'b0, 2); c_esp = 32'd12; fire(); check_ok("R7 exact fit 16");
        set_good(1, 1'b1, 1'b0, 2); c_esp = 32'd11; check_fault("R7", 2'd2, 16'h0058, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule